// File: doc/BRIEF.md
# Partitionable-Endpoint DMA Validation Unit

This block guards inbound DMA traffic in a PCIe host bridge. Every request carries a trusted 16-bit requester ID (bus in bits 15:8, device in bits 7:3, function in bits 2:0) and an untrusted 64-bit bus address supplied by a device driver. The unit resolves the requester ID to a partitionable-endpoint (PE) number. It then checks the address against that PE's DMA window. Only after both steps does it translate the 4 KB bus page to a system page, through a small fully associative cache of translation entries. Each PE has its own address space, so the cache is tagged by PE and bus page together. Translation lets a device with 32-bit addressing reach any system page, and lets scattered system pages appear contiguous on the bus.

A cache miss stalls the unit, which has one miss outstanding at a time. The unit requests the entry on a fetch port, and a memory-side responder returns it. Every PE has a freeze flag. A permission fault or an invalid fetched entry freezes the PE that made the request. If that PE is a physical function, the fault also freezes every PE whose parent is that function, so its virtual functions stop together with it. While a PE is frozen, its writes are dropped and its reads complete with all ones. Software clears the freeze of one PE at a time through the configuration write port.

Top module: `pe_dma_guard`

## Requirements
- R1: A request whose requester ID matches no loaded entry with its valid flag set completes with status REJECT (2'd1), address 0, and issues no fetch. Configuration select 2'd0 loads a table entry: data bits 15:0 hold the ID, bits 16+PE_W-1:16 hold the PE, and bit 16+PE_W is the valid flag.
- R2: A request is rejected (status 2'd1, no fetch, PE not frozen) when its address bits 63:12+WIN_W are not zero, or when its bus page (bits 12+WIN_W-1:12) is not below the PE's page limit. The page limit is set by select 2'd1 from data bits WIN_W:0. A page one below the limit is accepted.
- R3: An accepted request completes with status OK (2'd0) and address {system page, request address bits 11:0}.
- R4: On a cache miss, fetch_valid stays high with the PE and bus page until fetch_rsp_valid arrives, and req_ready stays low meanwhile. Exactly one fetch is issued per miss.
- R5: A repeated request to a cached (PE, bus page) issues no fetch.
- R6: Two PEs using the same bus page each fetch their own entry and receive different system addresses.
- R7: Fetched valid entries fill the C_N cache slots in round-robin order, so the oldest fill is evicted first.
- R8: A write to a page without write permission, a read from a page without read permission, or a fetched entry whose valid flag is clear completes as REJECT and freezes the requesting PE.
- R9: A request from a frozen PE issues no fetch and completes with status FROZEN (2'd2). A read returns an all-ones address, and a write returns address 0 and is not forwarded. Other PEs proceed normally.
- R10: Select 2'd2 sets a PE's parent (data bits PE_W-1:0). After reset, every PE is its own parent. A fault on a PE that is its own parent also freezes every PE whose parent it is. A fault on any other PE freezes only that PE.
- R11: Select 2'd3 with cfg_idx holding a PE number clears that PE's freeze.
- R12: After reset, req_ready is high, rsp_valid and fetch_valid are low, no PE is frozen, and every requester ID is unmapped.
- R13: Each response is a single-cycle pulse that echoes the request's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | DMA request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_rid | input | 16 | Requester ID |
| req_addr | input | 64 | Bus address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Response pulse |
| rsp_tag | output | TAG_W | Echoed tag |
| rsp_addr | output | 64 | Translated address, or 0 / all ones |
| rsp_status | output | 2 | 0 OK, 1 REJECT, 2 FROZEN |
| fetch_valid | output | 1 | Translation entry fetch pending |
| fetch_pe | output | PE_W | PE of the fetch |
| fetch_page | output | WIN_W | Bus page of the fetch |
| fetch_rsp_valid | input | 1 | Fetched entry returned |
| fetch_rsp_ok | input | 1 | Entry valid flag |
| fetch_rsp_rd | input | 1 | Read permitted |
| fetch_rsp_wr | input | 1 | Write permitted |
| fetch_rsp_page | input | 52 | System page number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 ID entry, 1 page limit, 2 parent, 3 clear freeze |
| cfg_idx | input | 8 | Table entry or PE number |
| cfg_data | input | 17+PE_W | Write data |

## Verification
The bench builds the unit with RT_N=8, PE_W=3, C_N=4 and WIN_W=16. A four-slot cache lets a handful of distinct pages force evictions, so round-robin order and misses after eviction become observable. Eight PEs are enough to form a physical function with two virtual functions next to an unrelated PE, so group freezing and its limits can be exercised. The 16-bit window places the page limit and the above-window address bits within easy reach of directed vectors.

// File: rtl/pe_dma_guard.sv
module pe_dma_guard #(
  parameter int RT_N  = 64,
  parameter int PE_W  = 5,
  parameter int C_N   = 16,
  parameter int WIN_W = 20,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [15:0]       req_rid,
  input  logic [63:0]       req_addr,
  input  logic              req_wr,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [63:0]       rsp_addr,
  output logic [1:0]        rsp_status,
  output logic              fetch_valid,
  output logic [PE_W-1:0]   fetch_pe,
  output logic [WIN_W-1:0]  fetch_page,
  input  logic              fetch_rsp_valid,
  input  logic              fetch_rsp_ok,
  input  logic              fetch_rsp_rd,
  input  logic              fetch_rsp_wr,
  input  logic [51:0]       fetch_rsp_page,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_idx,
  input  logic [16+PE_W:0]  cfg_data
);
  localparam int PE_N = 1 << PE_W;
  localparam int C_IW = $clog2(C_N);
  localparam logic [1:0] ST_OK = 2'd0, ST_REJ = 2'd1, ST_FRZ = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_FETCH} st_t;
  st_t state;

  logic [15:0]      q_rid;
  logic [63:0]      q_addr;
  logic             q_wr;
  logic [TAG_W-1:0] q_tag;

  logic             rt_v   [RT_N];
  logic [15:0]      rt_rid [RT_N];
  logic [PE_W-1:0]  rt_pe  [RT_N];
  logic [WIN_W:0]   win_lim [PE_N];
  logic [PE_W-1:0]  par    [PE_N];
  logic [PE_N-1:0]  frozen;

  logic             c_v  [C_N];
  logic [PE_W-1:0]  c_pe [C_N];
  logic [WIN_W-1:0] c_pg [C_N];
  logic             c_rd [C_N];
  logic             c_wr [C_N];
  logic [51:0]      c_sp [C_N];
  logic [C_IW-1:0]  rr;

  logic             rid_hit, c_hit, h_rd, h_wr, in_win, perm_ok, fault;
  logic [PE_W-1:0]  cur_pe;
  logic [51:0]      h_sp;
  logic [WIN_W-1:0] bpage;

  assign bpage       = q_addr[12 +: WIN_W];
  assign in_win      = (q_addr[63:12+WIN_W] == '0) && ({1'b0, bpage} < win_lim[cur_pe]);
  assign perm_ok     = q_wr ? h_wr : h_rd;
  assign req_ready   = (state == S_IDLE);
  assign fetch_valid = (state == S_FETCH);
  assign fetch_pe    = cur_pe;
  assign fetch_page  = bpage;
  assign fault = (state == S_EVAL && rid_hit && !frozen[cur_pe] && in_win && c_hit && !perm_ok)
              || (state == S_FETCH && fetch_rsp_valid && !fetch_rsp_ok);

  always_comb begin
    rid_hit = 1'b0;
    cur_pe  = '0;
    for (int i = 0; i < RT_N; i++)
      if (rt_v[i] && rt_rid[i] == q_rid) begin
        rid_hit = 1'b1;
        cur_pe  = rt_pe[i];
      end
    c_hit = 1'b0; h_rd = 1'b0; h_wr = 1'b0; h_sp = '0;
    for (int i = 0; i < C_N; i++)
      if (c_v[i] && c_pe[i] == cur_pe && c_pg[i] == bpage) begin
        c_hit = 1'b1; h_rd = c_rd[i]; h_wr = c_wr[i]; h_sp = c_sp[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RT_N; i++) begin
        rt_v[i] <= 1'b0; rt_rid[i] <= '0; rt_pe[i] <= '0;
      end
      for (int p = 0; p < PE_N; p++) begin
        win_lim[p] <= '0;
        par[p]     <= PE_W'(p);
      end
      frozen <= '0;
    end else begin
      if (cfg_we) begin
        for (int i = 0; i < RT_N; i++)
          if (cfg_sel == 2'd0 && cfg_idx == 8'(i)) begin
            rt_rid[i] <= cfg_data[15:0];
            rt_pe[i]  <= cfg_data[16 +: PE_W];
            rt_v[i]   <= cfg_data[16+PE_W];
          end
        for (int p = 0; p < PE_N; p++)
          if (cfg_idx == 8'(p)) begin
            if (cfg_sel == 2'd1) win_lim[p] <= cfg_data[WIN_W:0];
            if (cfg_sel == 2'd2) par[p] <= cfg_data[PE_W-1:0];
            if (cfg_sel == 2'd3) frozen[p] <= 1'b0;
          end
      end
      if (fault)
        for (int p = 0; p < PE_N; p++)
          if (PE_W'(p) == cur_pe || (par[cur_pe] == cur_pe && par[p] == cur_pe))
            frozen[p] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; rr <= '0;
      q_rid <= '0; q_addr <= '0; q_wr <= 1'b0; q_tag <= '0;
      rsp_valid <= 1'b0; rsp_tag <= '0; rsp_addr <= '0; rsp_status <= ST_OK;
      for (int i = 0; i < C_N; i++) begin
        c_v[i] <= 1'b0; c_pe[i] <= '0; c_pg[i] <= '0;
        c_rd[i] <= 1'b0; c_wr[i] <= 1'b0; c_sp[i] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          q_rid <= req_rid; q_addr <= req_addr; q_wr <= req_wr; q_tag <= req_tag;
          state <= S_EVAL;
        end
        S_EVAL: begin
          state      <= S_IDLE;
          rsp_valid  <= 1'b1;
          rsp_tag    <= q_tag;
          rsp_addr   <= '0;
          rsp_status <= ST_REJ;
          if (rid_hit && frozen[cur_pe]) begin
            rsp_status <= ST_FRZ;
            rsp_addr   <= q_wr ? 64'd0 : '1;
          end else if (rid_hit && in_win) begin
            if (!c_hit) begin
              rsp_valid <= 1'b0;
              state     <= S_FETCH;
            end else if (perm_ok) begin
              rsp_status <= ST_OK;
              rsp_addr   <= {h_sp, q_addr[11:0]};
            end
          end
        end
        S_FETCH: if (fetch_rsp_valid) begin
          if (fetch_rsp_ok) begin
            c_v[rr] <= 1'b1; c_pe[rr] <= cur_pe; c_pg[rr] <= bpage;
            c_rd[rr] <= fetch_rsp_rd; c_wr[rr] <= fetch_rsp_wr; c_sp[rr] <= fetch_rsp_page;
            rr    <= (rr == C_IW'(C_N-1)) ? '0 : rr + 1'b1;
            state <= S_EVAL;
          end else begin
            rsp_valid <= 1'b1; rsp_tag <= q_tag; rsp_addr <= '0; rsp_status <= ST_REJ;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_rsp_valid |=> fetch_valid);
  // R13
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  fault_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> frozen[$past(cur_pe)]);
  // R9
  frozen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_EVAL && rid_hit && frozen[cur_pe] |=> rsp_valid && rsp_status == ST_FRZ);
  // R1
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_EVAL && !rid_hit |=> rsp_valid && rsp_status == ST_REJ);
endmodule

// File: tb/pe_dma_guard_tb_top.sv
module pe_dma_guard_tb_top;
  localparam int PE_W = 3, WIN_W = 16, TAG_W = 8;
  localparam logic [1:0] OK = 2'd0, REJ = 2'd1, FRZ = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic req_ready;
  logic [15:0] req_rid = '0;
  logic [63:0] req_addr = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic rsp_valid;
  logic [TAG_W-1:0] rsp_tag;
  logic [63:0] rsp_addr;
  logic [1:0] rsp_status;
  logic fetch_valid;
  logic [PE_W-1:0] fetch_pe;
  logic [WIN_W-1:0] fetch_page;
  logic fetch_rsp_valid = 1'b0, fetch_rsp_ok = 1'b0, fetch_rsp_rd = 1'b0, fetch_rsp_wr = 1'b0;
  logic [51:0] fetch_rsp_page = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_idx = '0;
  logic [16+PE_W:0] cfg_data = '0;

  int nchk = 0, nfail = 0, fetch_cnt = 0;
  bit ready_bad = 1'b0;
  logic [PE_W-1:0] lf_pe;
  logic [WIN_W-1:0] lf_pg;

  always #10 clk = ~clk;

  pe_dma_guard #(.RT_N(8), .PE_W(PE_W), .C_N(4), .WIN_W(WIN_W), .TAG_W(TAG_W)) dut_i (
    .clk, .rst_n, .req_valid, .req_ready, .req_rid, .req_addr, .req_wr, .req_tag,
    .rsp_valid, .rsp_tag, .rsp_addr, .rsp_status, .fetch_valid, .fetch_pe, .fetch_page,
    .fetch_rsp_valid, .fetch_rsp_ok, .fetch_rsp_rd, .fetch_rsp_wr, .fetch_rsp_page,
    .cfg_we, .cfg_sel, .cfg_idx, .cfg_data);

  function automatic logic [51:0] sp(input int pe, input int pg);
    return 52'h40000 + 52'(pe) * 52'h1000 + 52'(pg) * 52'd7;
  endfunction

  // memory-side table: page 7 read-only, page 8 write-only, page 9 invalid
  always begin
    @(negedge clk);
    if (fetch_valid) begin
      fetch_cnt++;
      lf_pe = fetch_pe;
      lf_pg = fetch_page;
      repeat (2) begin
        @(negedge clk);
        if (req_ready) ready_bad = 1'b1;
      end
      fetch_rsp_valid = 1'b1;
      fetch_rsp_ok    = (fetch_page != 16'd9);
      fetch_rsp_rd    = (fetch_page != 16'd8);
      fetch_rsp_wr    = (fetch_page != 16'd7);
      fetch_rsp_page  = sp(int'(fetch_pe), int'(fetch_page));
      @(negedge clk);
      fetch_rsp_valid = 1'b0;
    end
  end

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h exp %h", rq, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] s, input int idx, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = 8'(idx); cfg_data = (17+PE_W)'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [15:0] rid, input logic [63:0] addr, input logic wr,
                     input logic [1:0] est, input int pe, input int efe, input string rq);
    logic [63:0] ea;
    int f0, w;
    logic [7:0] tg;
    tg = 8'(nchk);
    f0 = fetch_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_rid = rid; req_addr = addr; req_wr = wr; req_tag = tg;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 200) begin @(negedge clk); w++; end
    ea = (est == OK) ? {sp(pe, int'(addr[27:12])), addr[11:0]} :
         (est == FRZ && !wr) ? '1 : 64'd0;
    chk(rq, 64'(rsp_status), 64'(est));
    chk(rq, rsp_addr, ea);
    chk("R13", 64'(rsp_tag), 64'(tg));
    if (efe >= 0) begin
      chk(rq, 64'(fetch_cnt - f0), 64'(efe));
      if (efe == 1) begin
        chk("R4", 64'(lf_pe), 64'(pe));
        chk("R4", 64'(lf_pg), 64'(addr[27:12]));
      end
    end
  endtask

  typedef struct packed {
    logic [15:0] rid; logic [63:0] addr; logic wr; logic [1:0] st;
    logic fe; logic [2:0] pe; logic [3:0] rq;
  } vec_t;
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{16'h0100, 64'h3123,          1'b0, OK,  1'b1, 3'd1, 4'd4},  // R4 miss then OK
    '{16'h0100, 64'h3ABC,          1'b1, OK,  1'b0, 3'd1, 4'd5},  // R5 hit
    '{16'h0208, 64'h3456,          1'b0, OK,  1'b1, 3'd4, 4'd6},  // R6 same page other PE
    '{16'h0300, 64'h3000,          1'b0, REJ, 1'b0, 3'd0, 4'd1},  // R1 loaded but invalid
    '{16'h0100, 64'h10_0000,       1'b0, REJ, 1'b0, 3'd1, 4'd2},  // R2 page == limit
    '{16'h0100, 64'h100_0000_3000, 1'b0, REJ, 1'b0, 3'd1, 4'd2},  // R2 upper bits
    '{16'h0100, 64'hF_F004,        1'b0, OK,  1'b1, 3'd1, 4'd2},  // R2 limit-1
    '{16'h0101, 64'h5008,          1'b0, OK,  1'b1, 3'd2, 4'd3},  // R3
    '{16'h0102, 64'h6010,          1'b1, OK,  1'b1, 3'd3, 4'd7},  // R7 evicts (1,3)
    '{16'h0208, 64'h3FFF,          1'b0, OK,  1'b0, 3'd4, 4'd7},  // R7 still cached
    '{16'h0100, 64'h3000,          1'b0, OK,  1'b1, 3'd1, 4'd7},  // R7 refetch
    '{16'h0208, 64'h3004,          1'b1, OK,  1'b1, 3'd4, 4'd7},  // R7 refetch
    '{16'h0208, 64'h7010,          1'b1, REJ, 1'b1, 3'd4, 4'd8},  // R8 write to read-only
    '{16'h0208, 64'h3000,          1'b0, FRZ, 1'b0, 3'd4, 4'd9},  // R9 frozen read
    '{16'h0208, 64'h3000,          1'b1, FRZ, 1'b0, 3'd4, 4'd9},  // R9 frozen write
    '{16'h0100, 64'h3020,          1'b0, OK,  1'b0, 3'd1, 4'd9}   // R9 other PE unaffected
  };

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got hang exp completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", 64'(req_ready), 64'd1);
    chk("R12", 64'(rsp_valid), 64'd0);
    chk("R12", 64'(fetch_valid), 64'd0);
    run(16'h0100, 64'h3000, 1'b0, REJ, 1, 0, "R12");

    cfg(2'd0, 0, (1 << 19) | (1 << 16) | 'h0100);
    cfg(2'd0, 1, (1 << 19) | (2 << 16) | 'h0101);
    cfg(2'd0, 2, (1 << 19) | (3 << 16) | 'h0102);
    cfg(2'd0, 3, (1 << 19) | (4 << 16) | 'h0208);
    cfg(2'd0, 4, (5 << 16) | 'h0300);
    for (int p = 1; p < 6; p++) cfg(2'd1, p, 'h100);
    cfg(2'd2, 2, 1);
    cfg(2'd2, 3, 1);

    for (int i = 0; i < NV; i++)
      run(VEC[i].rid, VEC[i].addr, VEC[i].wr, VEC[i].st, int'(VEC[i].pe),
          int'(VEC[i].fe), $sformatf("R%0d", VEC[i].rq));

    // R11 clear freeze of PE4
    cfg(2'd3, 4, 0);
    run(16'h0208, 64'h3000, 1'b0, OK, 4, 0, "R11");

    // R10 physical-function fault freezes its virtual functions only
    run(16'h0100, 64'h8000, 1'b0, REJ, 1, 1, "R8");
    run(16'h0101, 64'h5000, 1'b0, FRZ, 2, 0, "R10");
    run(16'h0102, 64'h6000, 1'b1, FRZ, 3, 0, "R10");
    run(16'h0100, 64'h3000, 1'b0, FRZ, 1, 0, "R10");
    run(16'h0208, 64'h3000, 1'b0, OK,  4, -1, "R10");

    // R10 virtual-function fault freezes only itself; R8 invalid entry
    cfg(2'd3, 1, 0);
    cfg(2'd3, 2, 0);
    cfg(2'd3, 3, 0);
    run(16'h0102, 64'h9000, 1'b0, REJ, 3, 1, "R8");
    run(16'h0102, 64'h6000, 1'b0, FRZ, 3, 0, "R10");
    run(16'h0101, 64'h5000, 1'b0, OK,  2, -1, "R10");
    run(16'h0100, 64'h3000, 1'b0, OK,  1, -1, "R10");

    // R4 ready held low during every fetch
    chk("R4", 64'(ready_bad), 64'd0);
    finish_run();
  end
endmodule